// File: doc/BRIEF.md
# Dual Lookup-Table DAC Input Router

This block produces the 8-bit input bytes for two current-output DACs. Each DAC has two cascaded source selects. The first select picks the row that indexes that DAC's lookup table: either the most recently captured 6-bit ADC sample or a 6-bit row held in a control register. The second select picks the DAC byte: either the lookup-table entry at that row or an 8-bit override byte held in a control register. With all selects cleared, the ADC drives both tables. Setting the row select lets software step through the tables by hand. Setting the byte select bypasses the ADC and the table, and software drives the DAC directly.

Both tables and six control registers share one byte-wide register port with a 9-bit address. The control registers sit at 080h through 085h. Table 1 takes 64 bytes at 090h plus the row index, and table 2 takes 64 bytes at 0D0h plus the row index. The block also drives a sink/source direction bit and a 2-bit full-scale select code for each DAC. The analog converters, the current sources and the ADC itself are outside this block.

Top module: `dac_route_top`

## Requirements
- R1: After rst_ni is asserted, every control register and every table entry reads 00h, both DAC bytes are 00h, and both direction bits and both full-scale codes are 0.
- R2: A write to 090h+r or 0D0h+r (r = 0..63) stores a byte that reads back at the same address. Reads of addresses outside 080h..085h and 090h..10Fh return 00h. Writes to those addresses change no register, no table entry and no output.
- R3: The ADC row is captured at a clock edge only when adc_valid_i is high. Between strobes the last captured row is held, and adc_row_i has no effect on the outputs.
- R4: With control register 085h bits 4 and 5 at 0, dac1_byte_o equals table 1 at the captured ADC row. With bits 6 and 7 at 0, dac2_byte_o equals table 2 at the captured ADC row.
- R5: When 085h bit 4 is 1, table 1 is indexed by bits 5:0 of register 081h. When bit 6 is 1, table 2 is indexed by bits 5:0 of register 082h.
- R6: When 085h bit 5 is 1, dac1_byte_o equals register 083h. When bit 7 is 1, dac2_byte_o equals register 084h. In either case the table and the ADC have no effect on that DAC.
- R7: dir1_o follows bit 6 of register 080h, and dir2_o follows bit 7 of register 080h. Each changes at the clock edge that writes the register.
- R8: fs1_o follows bits 1:0 of register 085h, and fs2_o follows bits 3:2 of register 085h. Each changes at the clock edge that writes the register.
- R9: Each DAC byte is registered. It takes the value computed from the state left by edge k at edge k+1. It does not change if no write and no ADC strobe occurred at the edge before.
- R10: Registers 081h and 082h keep only bits 5:0. Bits 7:6 of these two registers always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register port write strobe |
| reg_addr_i | input | 9 | Register port byte address |
| reg_wdata_i | input | 8 | Register port write data |
| reg_rdata_o | output | 8 | Register port read data, combinational from the address |
| adc_row_i | input | 6 | ADC sample used as the table row |
| adc_valid_i | input | 1 | ADC sample strobe |
| dac1_byte_o | output | 8 | DAC1 input byte |
| dac2_byte_o | output | 8 | DAC2 input byte |
| dir1_o | output | 1 | DAC1 current direction |
| dir2_o | output | 1 | DAC2 current direction |
| fs1_o | output | 2 | DAC1 full-scale select code |
| fs2_o | output | 2 | DAC2 full-scale select code |

## Verification
Results have three different latencies. Read data is due in the same cycle as the address. The direction bits and full-scale codes are due at the edge that writes them. Each DAC byte is due one edge after the write or ADC strobe that changes its inputs. The reference model in the bench uses the same timing. At each rising edge it first computes the expected DAC bytes from the state it held before that edge, and only then applies the write and the ADC capture. Outputs are compared at the following falling edge, and read data is sampled 1 ns after the address settles.

// File: rtl/dac_route_pkg.sv
`timescale 1ns/1ps
package dac_route_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ROW_W  = 6;
  localparam int unsigned ADDR_W = 9;
  localparam int unsigned N_CTRL = 6;
  localparam int unsigned N_DAC  = 2;
  localparam logic [ADDR_W-1:0] CTRL_BASE = 9'h080;
  localparam logic [ADDR_W-1:0] TBL_BASE  = 9'h090;  // table n at TBL_BASE + n*2^ROW_W

  // per-DAC routing taken from the control registers
  typedef struct packed {
    logic              row_sel;   // 1: register row, 0: ADC row
    logic              byte_sel;  // 1: register byte, 0: table byte
    logic [ROW_W-1:0]  row_reg;
    logic [DATA_W-1:0] byte_reg;
  } path_cfg_t;
endpackage

// File: rtl/dac_route_regs.sv
`timescale 1ns/1ps
module dac_route_regs #(
  parameter int unsigned N_CTRL = 6,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ROW_W  = 6,
  localparam int unsigned IDX_W = (N_CTRL > 1) ? $clog2(N_CTRL) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [N_CTRL-1:0][DATA_W-1:0] ctrl_o
);
  localparam logic [DATA_W-1:0] ROW_MASK = DATA_W'((1 << ROW_W) - 1);

  for (genvar g = 0; g < N_CTRL; g++) begin : g_reg
    // registers 1 and 2 carry only a table row
    localparam logic [DATA_W-1:0] MASK = (g == 1 || g == 2) ? ROW_MASK : '1;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  ctrl_o[g] <= '0;
      else if (we_i && idx_i == IDX_W'(g))          ctrl_o[g] <= wdata_i & MASK;
    end
  end

  p_row_regs_narrow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (idx_i == IDX_W'(1))) |=> (ctrl_o[1][DATA_W-1:ROW_W] == '0));
endmodule

// File: rtl/dac_route_lut.sv
`timescale 1ns/1ps
module dac_route_lut #(
  parameter int unsigned N_TBL  = 2,
  parameter int unsigned ROW_W  = 6,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned N_ROWS = 1 << ROW_W,
  localparam int unsigned TBL_W  = (N_TBL > 1) ? $clog2(N_TBL) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [TBL_W-1:0]             tbl_i,
  input  logic [ROW_W-1:0]             row_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  input  logic [N_TBL-1:0][ROW_W-1:0]  lk_row_i,
  output logic [N_TBL-1:0][DATA_W-1:0] lk_data_o
);
  logic [DATA_W-1:0] mem [N_TBL][N_ROWS];

  for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mem[t][r] <= '0;
        else if (we_i && tbl_i == TBL_W'(t) && row_i == ROW_W'(r)) mem[t][r] <= wdata_i;
      end
    end
    assign lk_data_o[t] = mem[t][lk_row_i[t]];
  end

  assign rdata_o = mem[tbl_i][row_i];
endmodule

// File: rtl/dac_route_path.sv
`timescale 1ns/1ps
module dac_route_path
  import dac_route_pkg::*;
#(
  parameter int unsigned P_ROW_W  = ROW_W,
  parameter int unsigned P_DATA_W = DATA_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  path_cfg_t           cfg_i,
  input  logic [P_ROW_W-1:0]  adc_row_i,
  output logic [P_ROW_W-1:0]  row_o,
  input  logic [P_DATA_W-1:0] lut_data_i,
  output logic [P_DATA_W-1:0] dac_o
);
  logic [P_DATA_W-1:0] next_byte;

  assign row_o     = cfg_i.row_sel  ? cfg_i.row_reg  : adc_row_i;
  assign next_byte = cfg_i.byte_sel ? cfg_i.byte_reg : lut_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dac_o <= '0;
    else         dac_o <= next_byte;
  end

  p_bypass_byte_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i.byte_sel |=> (dac_o == $past(cfg_i.byte_reg)));
  p_table_byte_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i.byte_sel && !cfg_i.row_sel) |=> (dac_o == $past(lut_data_i)));
endmodule

// File: rtl/dac_route_top.sv
`timescale 1ns/1ps
module dac_route_top
  import dac_route_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [ROW_W-1:0]  adc_row_i,
  input  logic              adc_valid_i,
  output logic [DATA_W-1:0] dac1_byte_o,
  output logic [DATA_W-1:0] dac2_byte_o,
  output logic              dir1_o,
  output logic              dir2_o,
  output logic [1:0]        fs1_o,
  output logic [1:0]        fs2_o
);
  localparam int unsigned N_ROWS = 1 << ROW_W;
  localparam int unsigned IDX_W  = $clog2(N_CTRL);
  localparam int unsigned TBL_W  = (N_DAC > 1) ? $clog2(N_DAC) : 1;
  localparam logic [ADDR_W-1:0] CTRL_SPAN = ADDR_W'(N_CTRL);
  localparam logic [ADDR_W-1:0] TBL_SPAN  = ADDR_W'(N_DAC * N_ROWS);
  localparam int unsigned SEL_REG = 5;
  localparam int unsigned DIR_REG = 0;
  localparam int unsigned DIR_BIT = 6;

  // address decode
  logic [ADDR_W-1:0] ctrl_off, tbl_off;
  logic              ctrl_hit, tbl_hit;
  logic [IDX_W-1:0]  ctrl_idx;
  logic [TBL_W-1:0]  tbl_idx;
  logic [ROW_W-1:0]  tbl_row;

  assign ctrl_off = reg_addr_i - CTRL_BASE;
  assign tbl_off  = reg_addr_i - TBL_BASE;
  assign ctrl_hit = ctrl_off < CTRL_SPAN;
  assign tbl_hit  = tbl_off < TBL_SPAN;
  assign ctrl_idx = ctrl_off[IDX_W-1:0];
  assign tbl_idx  = tbl_off[ROW_W +: TBL_W];
  assign tbl_row  = tbl_off[ROW_W-1:0];

  logic [N_CTRL-1:0][DATA_W-1:0] ctrl;
  logic [DATA_W-1:0]             tbl_rdata;

  dac_route_regs #(.N_CTRL(N_CTRL), .DATA_W(DATA_W), .ROW_W(ROW_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i && ctrl_hit),
    .idx_i   (ctrl_idx),
    .wdata_i (reg_wdata_i),
    .ctrl_o  (ctrl)
  );

  // ADC sample capture
  logic [ROW_W-1:0] adc_row_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          adc_row_q <= '0;
    else if (adc_valid_i) adc_row_q <= adc_row_i;
  end

  logic [N_DAC-1:0][ROW_W-1:0]  lk_row;
  logic [N_DAC-1:0][DATA_W-1:0] lk_data;
  logic [N_DAC-1:0][DATA_W-1:0] dac_byte;
  logic [N_DAC-1:0]             dir;
  logic [N_DAC-1:0][1:0]        fs;

  dac_route_lut #(.N_TBL(N_DAC), .ROW_W(ROW_W), .DATA_W(DATA_W)) u_lut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i && tbl_hit),
    .tbl_i     (tbl_idx),
    .row_i     (tbl_row),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (tbl_rdata),
    .lk_row_i  (lk_row),
    .lk_data_o (lk_data)
  );

  for (genvar d = 0; d < N_DAC; d++) begin : g_dac
    path_cfg_t cfg;
    // select bits interleave per DAC: row select at 4+2d, byte select at 5+2d
    assign cfg.row_sel  = ctrl[SEL_REG][4 + 2*d];
    assign cfg.byte_sel = ctrl[SEL_REG][5 + 2*d];
    assign cfg.row_reg  = ctrl[1 + d][ROW_W-1:0];
    assign cfg.byte_reg = ctrl[1 + N_DAC + d];
    assign dir[d]       = ctrl[DIR_REG][DIR_BIT + d];
    assign fs[d]        = ctrl[SEL_REG][2*d +: 2];

    dac_route_path u_path (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_i      (cfg),
      .adc_row_i  (adc_row_q),
      .row_o      (lk_row[d]),
      .lut_data_i (lk_data[d]),
      .dac_o      (dac_byte[d])
    );
  end

  assign reg_rdata_o = ctrl_hit ? ctrl[ctrl_idx] : (tbl_hit ? tbl_rdata : '0);
  assign dac1_byte_o = dac_byte[0];
  assign dac2_byte_o = dac_byte[1];
  assign dir1_o      = dir[0];
  assign dir2_o      = dir[1];
  assign fs1_o       = fs[0];
  assign fs2_o       = fs[1];

  p_adc_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_valid_i |=> $stable(adc_row_q));
  p_dac_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_we_i && !adc_valid_i) |-> ##2 $stable({dac2_byte_o, dac1_byte_o}));
  p_ctrl_untouched_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_hit) |=> $stable(ctrl));
  p_dir_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && ctrl_hit && ctrl_idx == IDX_W'(DIR_REG))
      |=> ({dir2_o, dir1_o} == $past(reg_wdata_i[DIR_BIT +: 2])));
  p_fs_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && ctrl_hit && ctrl_idx == IDX_W'(SEL_REG))
      |=> ({fs2_o, fs1_o} == $past(reg_wdata_i[3:0])));
endmodule

// File: tb/dac_route_top_test.sv
`timescale 1ns/1ps
module dac_route_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [8:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [5:0] adc = '0;
  logic       valid = 1'b0;
  logic [7:0] dac1, dac2;
  logic       dir1, dir2;
  logic [1:0] fs1, fs2;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  dac_route_top uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .adc_row_i(adc), .adc_valid_i(valid),
    .dac1_byte_o(dac1), .dac2_byte_o(dac2), .dir1_o(dir1), .dir2_o(dir2),
    .fs1_o(fs1), .fs2_o(fs2)
  );

  // behavioural reference
  int        tb [2][64];
  logic [7:0] c [6];
  int        aq;
  int        e_dac [2];

  function automatic int model_read(int a);
    if (a >= 'h80 && a <= 'h85) return int'(c[a - 'h80]);
    if (a >= 'h90 && a <= 'hCF) return tb[0][a - 'h90];
    if (a >= 'hD0 && a <= 'h10F) return tb[1][a - 'hD0];
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < 2; t++) for (int r = 0; r < 64; r++) tb[t][r] = 0;
      for (int i = 0; i < 6; i++) c[i] = '0;
      aq = 0; e_dac[0] = 0; e_dac[1] = 0;
    end else begin
      for (int d = 0; d < 2; d++) begin
        int row;
        row = c[5][4 + 2*d] ? int'(c[1+d] & 8'h3F) : aq;
        e_dac[d] = c[5][5 + 2*d] ? int'(c[3+d]) : tb[d][row];
      end
      if (valid) aq = int'(adc);
      if (we) begin
        int a;
        a = int'(addr);
        if (a >= 'h80 && a <= 'h85) c[a - 'h80] = (a == 'h81 || a == 'h82) ? (wdata & 8'h3F) : wdata;
        else if (a >= 'h90 && a <= 'hCF) tb[0][a - 'h90] = int'(wdata);
        else if (a >= 'hD0 && a <= 'h10F) tb[1][a - 'hD0] = int'(wdata);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison of outputs
  always @(negedge clk) if (rst_n && !done) begin
    chk("R4/R5/R6/R9 dac1", int'(dac1), e_dac[0]);
    chk("R4/R5/R6/R9 dac2", int'(dac2), e_dac[1]);
    chk("R7 dir", int'({dir2, dir1}), int'(c[0][7:6]));
    chk("R8 fs", int'({fs2, fs1}), int'(c[5][3:0]));
  end

  task automatic wr(int a, int d);
    @(negedge clk); addr = 9'(a); wdata = 8'(d); we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic sample(int v, bit vld);
    @(negedge clk); adc = 6'(v); valid = vld;
    @(negedge clk); valid = 1'b0;
  endtask

  task automatic rd(string tag, int a);
    @(negedge clk); we = 1'b0; addr = 9'(a);
    #1 chk(tag, int'(rdata), model_read(a));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    for (int i = 'h80; i <= 'h85; i++) rd("R1 ctrl reset", i);
    rd("R1 table1 reset", 'h90);
    rd("R1 table2 reset", 'h10F);
    chk("R1 dac reset", int'({dac2, dac1}), 0);
    chk("R1 dir/fs reset", int'({dir2, dir1, fs2, fs1}), 0);

    // R2: fill both tables and read back
    for (int r = 0; r < 64; r++) wr('h90 + r, (r * 37 + 11) & 255);
    for (int r = 0; r < 64; r++) wr('hD0 + r, ((r * 53) ^ 8'hA5) & 255);
    rd("R2 tbl1 first", 'h90);  rd("R2 tbl1 last", 'hCF);
    rd("R2 tbl2 first", 'hD0);  rd("R2 tbl2 last", 'h10F);
    chk("R2 tbl2 last value", int'(rdata), ((63 * 53) ^ 8'hA5) & 255);

    // R2: unmapped addresses
    wr('h86, 'hFF); wr('h8F, 'hFF); wr('h110, 'hFF); wr('h1FF, 'hFF); wr('h000, 'hFF);
    rd("R2 unmapped 86", 'h86); rd("R2 unmapped 110", 'h110); rd("R2 unmapped 1FF", 'h1FF);
    rd("R2 ctrl5 untouched", 'h85);
    idle(2);
    chk("R2 dac after unmapped", int'(dac1), 11);

    // R3/R4: ADC samples drive both tables
    sample(5, 1); idle(1);
    chk("R4 dac1 row5", int'(dac1), (5 * 37 + 11) & 255);
    chk("R4 dac2 row5", int'(dac2), ((5 * 53) ^ 8'hA5) & 255);
    sample(63, 1); sample(0, 1); sample(42, 1);
    sample(17, 0); sample(9, 0); idle(3);
    chk("R3 held row", int'(dac1), (42 * 37 + 11) & 255);

    // R10 / R5: register-driven rows
    wr('h81, 'hFF); rd("R10 ctrl1 masked", 'h81);
    chk("R10 ctrl1 value", int'(rdata), 'h3F);
    wr('h82, 'hC7); rd("R10 ctrl2 masked", 'h82);
    wr('h85, 'h10); idle(1);
    chk("R5 dac1 reg row", int'(dac1), (63 * 37 + 11) & 255);
    chk("R5 dac2 still adc", int'(dac2), ((42 * 53) ^ 8'hA5) & 255);
    wr('h85, 'h50); idle(1);
    chk("R5 dac2 reg row", int'(dac2), ((7 * 53) ^ 8'hA5) & 255);
    sample(3, 1); idle(2);

    // R6: direct bytes
    wr('h83, 'h5A); wr('h84, 'hC3);
    wr('h85, 'hA0); idle(1);
    chk("R6 dac1 direct", int'(dac1), 'h5A);
    chk("R6 dac2 direct", int'(dac2), 'hC3);
    sample(20, 1); wr('h90 + 20, 'h00); idle(2);
    chk("R6 adc ignored", int'({dac2, dac1}), 'hC35A);

    // R7 / R8
    wr('h80, 'h40); chk("R7 dir1 only", int'({dir2, dir1}), 1);
    wr('h80, 'h80); chk("R7 dir2 only", int'({dir2, dir1}), 2);
    wr('h85, 'h0E); chk("R8 fs codes", int'({fs2, fs1}), 'hE);
    idle(2);

    // mixed traffic, compared every cycle against the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      @(negedge clk);
      valid = lfsr[0];
      adc   = lfsr[6:1];
      we    = lfsr[7] | lfsr[8];
      wdata = lfsr[15:8];
      case (lfsr[11:9])
        3'd0: addr = 9'h085;
        3'd1: addr = 9'h081;
        3'd2: addr = 9'h082;
        3'd3: addr = 9'h083;
        3'd4: addr = 9'h084;
        3'd5: addr = 9'h090 + 9'(lfsr[5:0]);
        3'd6: addr = 9'h0D0 + 9'(lfsr[5:0]);
        default: addr = 9'h080;
      endcase
    end
    @(negedge clk); we = 1'b0; valid = 1'b0;
    idle(3);
    for (int i = 'h80; i <= 'h85; i++) rd("R2 final ctrl", i);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule